// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This combinational unit settles the data hazards of a five-stage, in-order integer pipeline. The pipeline registers, register file and ALU stay outside it. For each of the two ALU operands, it compares the source register number of the instruction in execute with the destination register numbers of the two older instructions that have not yet retired. It then drives a 2-bit select for the operand multiplexer. When both older instructions write the same register, the younger producer wins.

The unit also detects a load followed directly by an instruction that consumes the loaded register. In that case it raises three equal controls for one cycle. The first freezes the program counter. The second freezes the fetch/decode register, so the consumer waits in decode. The third clears the control bits entering execute, so execute receives a bubble. On the next cycle the load has reached the write-back register, and the bypass from that register supplies the operand.

Top module: `hazard_unit`

## Requirements
- R1: Each operand select uses 2'b00 for the register-file value, 2'b10 for the memory-stage ALU result and 2'b01 for the write-back-stage value; 2'b11 never appears.
- R2: Operand A selects 2'b10 when the memory stage writes a register, its destination is nonzero and equals the execute-stage rs; operand B does the same against the execute-stage rt.
- R3: An operand selects 2'b01 when the write-back stage writes a register, its destination is nonzero and equals that operand's source, and the memory stage does not qualify for the same operand.
- R4: When both older stages qualify for one operand, the select is 2'b10 (the newer result wins).
- R5: A source register number of 0 never produces a bypass; its select stays 2'b00.
- R6: A stage whose register-write enable is low is never chosen as a bypass source, even when its destination matches.
- R7: A stall is raised when the execute instruction reads memory and its rt equals the rs or the rt of the decode instruction. The rt may be register 0.
- R8: No stall is raised while the execute instruction does not read memory, whatever the register numbers are.
- R9: The PC hold, fetch/decode hold and control bubble outputs always carry the same value.
- R10: In a pipeline where a load writing register r is followed directly by an instruction reading r, exactly one stall cycle occurs. When the consumer then reaches execute, its select is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| ex_rs | input | 5 | First source register of the execute instruction |
| ex_rt | input | 5 | Second source register of the execute instruction |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register in the memory-stage register |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination register in the write-back-stage register |
| wb_reg_write | input | 1 | Write-back-stage instruction writes a register |
| fwd_a | output | 2 | Select for ALU operand A |
| fwd_b | output | 2 | Select for ALU operand B |
| pc_hold | output | 1 | Do not write the PC |
| ifid_hold | output | 1 | Do not write the fetch/decode register |
| ctrl_bubble | output | 1 | Zero the control bits entering execute |

## Verification
Bypass selection and the load-use interlock can both be active in the same cycle. This happens when a load sits in execute while its own sources are being bypassed from the two older stages. Random register numbers are drawn from a narrow range, so the destinations often match the sources. Every cycle, both selects and the stall controls are compared against bench functions that are evaluated separately. A directed sequence in a small register-number pipeline model checks that the single stall cycle hands the operand over to the write-back bypass.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    parameter int REG_W = 5;
    localparam int NUM_REGS = 1 << REG_W;

    typedef logic [REG_W-1:0] regnum_t;

    typedef enum logic [1:0] {
        BYP_REGFILE = 2'b00,
        BYP_WBACK   = 2'b01,
        BYP_MEMRES  = 2'b10
    } byp_sel_t;

    // A stage is a usable producer only if it writes a nonzero register.
    function automatic logic producer_hit(input regnum_t src,
                                          input regnum_t dst,
                                          input logic    wr);
        return wr && (dst != '0) && (dst == src);
    endfunction
endpackage

// File: rtl/bypass_select.sv
module bypass_select
    import hazard_pkg::*;
(
    input  regnum_t  src,
    input  regnum_t  mem_rd,
    input  logic     mem_wr,
    input  regnum_t  wb_rd,
    input  logic     wb_wr,
    output byp_sel_t sel
);
    logic mem_hit;
    logic wb_hit;

    assign mem_hit = producer_hit(src, mem_rd, mem_wr);
    assign wb_hit  = producer_hit(src, wb_rd, wb_wr);

    always_comb begin
        if (mem_hit)
            sel = BYP_MEMRES;
        else if (wb_hit)
            sel = BYP_WBACK;
        else
            sel = BYP_REGFILE;
    end

    always_comb begin
        AST_SEL_LEGAL: assert (sel != 2'b11);                                  // R1
        AST_ZERO_SRC_NO_BYPASS: assert (src != '0 || sel == BYP_REGFILE);      // R5
        AST_IDLE_STAGES_NO_BYPASS: assert (mem_wr || wb_wr || sel == BYP_REGFILE); // R6
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import hazard_pkg::*;
(
    input  regnum_t id_rs,
    input  regnum_t id_rt,
    input  regnum_t ex_rt,
    input  logic    ex_mem_read,
    output logic    stall
);
    logic rs_dep;
    logic rt_dep;

    assign rs_dep = (ex_rt == id_rs);
    assign rt_dep = (ex_rt == id_rt);
    assign stall  = ex_mem_read && (rs_dep || rt_dep);

    always_comb begin
        AST_STALL_ONLY_ON_LOAD: assert (!stall || ex_mem_read);                // R8
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
(
    input  logic [4:0] id_rs,
    input  logic [4:0] id_rt,
    input  logic [4:0] ex_rs,
    input  logic [4:0] ex_rt,
    input  logic       ex_mem_read,
    input  logic [4:0] mem_rd,
    input  logic       mem_reg_write,
    input  logic [4:0] wb_rd,
    input  logic       wb_reg_write,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       pc_hold,
    output logic       ifid_hold,
    output logic       ctrl_bubble
);
    localparam int NUM_OPS = 2;

    regnum_t  op_src [NUM_OPS];
    byp_sel_t op_sel [NUM_OPS];
    logic     stall;

    assign op_src[0] = ex_rs;
    assign op_src[1] = ex_rt;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        bypass_select u_sel (
            .src    (op_src[g]),
            .mem_rd (mem_rd),
            .mem_wr (mem_reg_write),
            .wb_rd  (wb_rd),
            .wb_wr  (wb_reg_write),
            .sel    (op_sel[g])
        );
    end

    load_use_detect u_lud (
        .id_rs       (id_rs),
        .id_rt       (id_rt),
        .ex_rt       (ex_rt),
        .ex_mem_read (ex_mem_read),
        .stall       (stall)
    );

    assign fwd_a       = op_sel[0];
    assign fwd_b       = op_sel[1];
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign ctrl_bubble = stall;

    always_comb begin
        AST_STALL_OUTPUTS_AGREE: assert (pc_hold == ifid_hold && ifid_hold == ctrl_bubble); // R9
        AST_SAME_SRC_SAME_SEL: assert (ex_rs != ex_rt || fwd_a == fwd_b);                 // R2
    end
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] id_rs, id_rt, ex_rs, ex_rt, mem_rd, wb_rd;
    logic       ex_mem_read, mem_reg_write, wb_reg_write;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_hold, ifid_hold, ctrl_bubble;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    hazard_unit dut (
        .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_mem_read(ex_mem_read), .mem_rd(mem_rd), .mem_reg_write(mem_reg_write),
        .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .ctrl_bubble(ctrl_bubble)
    );

    function automatic logic [1:0] exp_sel(input logic [4:0] s);
        if (mem_reg_write && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_reg_write && wb_rd != 0 && wb_rd == s)   return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall();
        return ex_mem_read && (ex_rt == id_rs || ex_rt == id_rt);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] a, b, c, d, input logic mr,
                         input logic [4:0] md, input logic mw,
                         input logic [4:0] wd, input logic ww);
        @(negedge clk);
        id_rs = a; id_rt = b; ex_rs = c; ex_rt = d; ex_mem_read = mr;
        mem_rd = md; mem_reg_write = mw; wb_rd = wd; wb_reg_write = ww;
        #1;
    endtask

    task automatic check_all(input string tag);
        check({tag, " R2/R3 fwd_a"}, fwd_a, exp_sel(ex_rs));
        check({tag, " R2/R3 fwd_b"}, fwd_b, exp_sel(ex_rt));
        check({tag, " R7 stall"}, pc_hold, exp_stall());
        check({tag, " R9 agree"}, {ifid_hold, ctrl_bubble}, {pc_hold, pc_hold});
    endtask

    typedef struct packed {
        logic [4:0] rs, rt, rd;
        logic       wr, mr;
    } slot_t;

    initial begin
        int seed = 17;
        void'($urandom(seed));

        // Reset state / all-idle inputs
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R1 idle fwd_a", fwd_a, 0);
        check("R8 idle stall", pc_hold, 0);

        // R2: memory-stage bypass on A and B
        drive(0, 0, 3, 4, 0, 3, 1, 0, 0);
        check("R2 fwd_a mem", fwd_a, 2'b10);
        drive(0, 0, 3, 4, 0, 4, 1, 0, 0);
        check("R2 fwd_b mem", fwd_b, 2'b10);
        // R3: write-back bypass
        drive(0, 0, 6, 7, 0, 9, 1, 7, 1);
        check("R3 fwd_b wb", fwd_b, 2'b01);
        // R4: both qualify
        drive(0, 0, 5, 5, 0, 5, 1, 5, 1);
        check("R4 fwd_a prio", fwd_a, 2'b10);
        check("R4 fwd_b prio", fwd_b, 2'b10);
        // R5: register 0
        drive(0, 0, 0, 0, 0, 0, 1, 0, 1);
        check("R5 zero a", fwd_a, 0);
        check("R5 zero b", fwd_b, 0);
        // R6: write enable low
        drive(0, 0, 8, 8, 0, 8, 0, 8, 0);
        check("R6 no wr a", fwd_a, 0);
        drive(0, 0, 8, 8, 0, 8, 0, 8, 1);
        check("R6 mem off wb on", fwd_a, 2'b01);
        // R7: load-use on rs, on rt, rt==0
        drive(2, 9, 1, 2, 1, 0, 0, 0, 0);
        check("R7 rs dep", pc_hold, 1);
        drive(9, 2, 1, 2, 1, 0, 0, 0, 0);
        check("R7 rt dep", ctrl_bubble, 1);
        drive(0, 9, 1, 0, 1, 0, 0, 0, 0);
        check("R7 rt zero", ifid_hold, 1);
        drive(3, 4, 1, 2, 1, 0, 0, 0, 0);
        check("R7 no dep", pc_hold, 0);
        // R8: no load
        drive(2, 2, 2, 2, 0, 2, 1, 2, 1);
        check("R8 no load", pc_hold, 0);
        // Stall and bypass in the same cycle
        drive(4, 1, 4, 4, 1, 4, 1, 4, 1);
        check_all("combo");

        // Random traffic
        for (int i = 0; i < 2000; i++) begin
            drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
                  $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1));
            check_all("rand");
        end

        // R10: register-number pipeline model, lw r1 then add r2 <- r1,r3
        begin
            slot_t prog [4];
            slot_t s_id, s_ex, s_mem, s_wb, nop;
            int pc = 1;
            int stalls = 0;
            int add_sel = -1;
            nop = '0;
            prog[0] = '{rs:4, rt:1, rd:1, wr:1, mr:1};
            prog[1] = '{rs:1, rt:3, rd:2, wr:1, mr:0};
            prog[2] = nop;
            prog[3] = nop;
            s_id = prog[0]; s_ex = nop; s_mem = nop; s_wb = nop;
            for (int cyc = 0; cyc < 6; cyc++) begin
                drive(s_id.rs, s_id.rt, s_ex.rs, s_ex.rt, s_ex.mr,
                      s_mem.rd, s_mem.wr, s_wb.rd, s_wb.wr);
                if (s_ex.rd == 2 && s_ex.wr) add_sel = fwd_a;
                s_wb = s_mem; s_mem = s_ex;
                if (pc_hold) begin
                    stalls++;
                    s_ex = nop;
                end else begin
                    s_ex = s_id;
                    s_id = (pc < 4) ? prog[pc] : nop;
                    pc++;
                end
            end
            check("R10 stall count", stalls, 1);
            check("R10 consumer select", add_sel, 2'b01);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule